// File: doc/BRIEF.md
# SDRAM Data Latency and Mask Pipeline

This block models the data-side timing of a single synchronous DRAM device. It is meant to sit inside a device model or a controller testbench. It takes the command strobes (read, write, precharge, burst stop, mode set) together with the clock enable and the programmed column latency. From these it decides which clock edges carry a read beat on the data pins, and which write beats the device takes in.

On the read side, a read command issues `BURST_LEN` beats, one per clock. The beat data is supplied by the caller. Each beat passes through a latency pipeline whose tap is chosen by the column latency. A byte mask acts on read beats two clocks after it is sampled, and a lane that is not driven shows zero, standing for high impedance. On the write side, the write command and each beat that follows are accepted combinationally in the same clock, and the mask takes effect with no delay.

A low clock enable freezes the whole block one clock after it is sampled. A command issued directly after a mode-set command raises a one-clock violation flag.

Top module: `sdram_dq_timing`

## Requirements
- R1: With column latency L (1..MAX_CL; other codes act as MAX_CL), the read beat whose data sat on `rd_beat` at clock edge k is shown on `dq_out` with `dq_valid` high during the cycle following edge k+L-1, so that it is sampled at edge k+L. A read command issues `BURST_LEN` consecutive beats, starting at its own edge.
- R2: A `dqm` bit (bit i covers byte lane i, bits [8i+7:8i]) sampled high at edge x clears `dq_oe[i]` and zeroes that lane of `dq_out` for the beat shown after edge x+1 only.
- R3: `wr_byte_en[i]` equals `wr_accept` AND NOT `dqm[i]` in the same cycle, with no delay.
- R4: `wr_accept` is high in the cycle of a write command and in the following `BURST_LEN-1` cycles with no other command, and is low after that.
- R5: A precharge at edge p during a read cuts the burst so that no beat is valid at sample edges p+L and later, while beats due before that still appear.
- R6: A burst stop at edge p during a read lets the beats issued before edge p drain through the latency pipeline, and no later beat appears.
- R7: `cke` sampled low at edge a freezes the block at edge a+1: outputs after a+1 equal those after a, no beat is issued, no command takes effect, and `wr_accept` is low while frozen.
- R8: A read command ends write acceptance at once: `wr_accept` is low in its cycle and stays low afterwards.
- R9: A command of any kind at the edge right after a mode-set command raises `mode_set_err` for the cycle after that edge. A gap of one idle clock raises nothing.
- R10: After reset, `dq_valid`, `dq_oe`, `dq_out`, `wr_accept`, `wr_byte_en` and `mode_set_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable, freezes the block one clock after it is sampled low |
| cmd_read | input | 1 | Read command strobe |
| cmd_write | input | 1 | Write command strobe |
| cmd_precharge | input | 1 | Precharge command strobe |
| cmd_burst_stop | input | 1 | Burst stop command strobe |
| cmd_mode_set | input | 1 | Mode register set command strobe |
| cas_lat | input | CL_W | Programmed column latency, 1..MAX_CL |
| rd_beat | input | DW | Read data for the beat issued at this edge |
| dqm | input | LANES | Per-byte-lane data mask |
| dq_oe | output | LANES | Per-lane output drive enable |
| dq_valid | output | 1 | A read beat occupies this cycle |
| dq_out | output | DW | Read data, zero in lanes not driven |
| wr_accept | output | 1 | Write beat taken this cycle |
| wr_byte_en | output | LANES | Per-lane write enable of the taken beat |
| mode_set_err | output | 1 | Command too soon after a mode-set command |

## Verification
The bench builds the block with a 16-bit data path, which gives two byte lanes, and keeps the defaults of four beats per burst, a maximum latency of three and a read-mask delay of two. With two lanes it can mask one lane while the other is still driven on both the read and the write side. The maximum latency of three lets it run all three latencies against the same burst. It can also place a precharge or burst stop where some beats are already in flight and others are not yet issued.

// File: rtl/sdram_dq_pkg.sv
package sdram_dq_pkg;

   // Command strobes sampled at one clock edge
   typedef struct packed {
      logic rd;
      logic wr;
      logic pre;
      logic bst;
      logic mrs;
   } dq_cmd_t;

   function automatic logic cmd_any(input dq_cmd_t c);
      return c.rd | c.wr | c.pre | c.bst | c.mrs;
   endfunction

endpackage

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe
   import sdram_dq_pkg::*;
#(
   parameter int DW        = 8,
   parameter int LANE_W    = 8,
   parameter int BURST_LEN = 4,
   parameter int MAX_CL    = 3,
   parameter int MASK_LAT  = 2,
   localparam int LANES    = DW / LANE_W,
   localparam int CNT_W    = $clog2(BURST_LEN + 1),
   localparam int CL_W     = $clog2(MAX_CL + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  dq_cmd_t          cmd,
   input  logic [CL_W-1:0]  cas_lat,
   input  logic [DW-1:0]    rd_beat,
   input  logic [LANES-1:0] dqm,
   output logic             dq_valid,
   output logic [LANES-1:0] dq_oe,
   output logic [DW-1:0]    dq_out
);

   logic [CNT_W-1:0] remain;
   logic             more, cut, issue;

   assign more  = (remain != '0);
   assign cut   = cmd.pre | cmd.bst | cmd.wr;
   assign issue = en & (cmd.rd | (more & ~cut));

   // Beats still to issue after the current one
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         remain <= '0;
      else if (en) begin
         if (cmd.rd)
            remain <= CNT_W'(BURST_LEN - 1);
         else if (cut)
            remain <= '0;
         else if (more)
            remain <= remain - 1'b1;
      end
   end

   // Latency pipeline: stage i holds a beat issued i+1 edges ago
   logic          st_v [MAX_CL];
   logic [DW-1:0] st_d [MAX_CL];

   for (genvar i = 0; i < MAX_CL; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st_v[0] <= 1'b0;
               st_d[0] <= '0;
            end else if (en) begin
               st_v[0] <= issue;
               st_d[0] <= rd_beat;
            end
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st_v[i] <= 1'b0;
               st_d[i] <= '0;
            end else if (en) begin
               st_v[i] <= st_v[i-1];
               st_d[i] <= st_d[i-1];
            end
         end
      end
   end

   // Read mask pipeline, fixed delay independent of latency
   logic [LANES-1:0] mk [MASK_LAT];

   for (genvar m = 0; m < MASK_LAT; m++) begin : g_mask
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mk[m] <= '0;
         else if (en)
            mk[m] <= (m == 0) ? dqm : mk[(m == 0) ? 0 : m-1];
      end
   end

   // Latency tap select, out-of-range codes fall back to the longest tap
   logic [CL_W-1:0] tap;
   always_comb begin
      if (cas_lat == '0 || int'(cas_lat) > MAX_CL)
         tap = CL_W'(MAX_CL - 1);
      else
         tap = cas_lat - 1'b1;
   end

   logic          sel_v;
   logic [DW-1:0] sel_d;
   assign sel_v    = st_v[tap];
   assign sel_d    = st_d[tap];
   assign dq_valid = sel_v;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign dq_oe[l] = sel_v & ~mk[MASK_LAT-1][l];
      assign dq_out[l*LANE_W +: LANE_W] = dq_oe[l] ? sel_d[l*LANE_W +: LANE_W] : '0;
   end

   AST_CUT_NO_NEW_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (cmd.pre || cmd.bst) && !cmd.rd) |=> !st_v[0]); // R5

   AST_STOP_NO_NEW_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cmd.bst && !cmd.rd) |=> !st_v[0]); // R6

   AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(st_v[0]) && $stable(mk[0]))); // R7

   AST_READ_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cmd.rd) |=> st_v[0]); // R1

endmodule

// File: rtl/sdram_wr_gate.sv
module sdram_wr_gate
   import sdram_dq_pkg::*;
#(
   parameter int BURST_LEN = 4,
   parameter int LANES     = 1,
   localparam int CNT_W    = $clog2(BURST_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  dq_cmd_t          cmd,
   input  logic [LANES-1:0] dqm,
   output logic             wr_accept,
   output logic [LANES-1:0] wr_byte_en
);

   logic [CNT_W-1:0] left;
   logic             kill;

   assign kill = cmd.rd | cmd.pre | cmd.bst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         left <= '0;
      else if (en) begin
         if (kill)
            left <= '0;
         else if (cmd.wr)
            left <= CNT_W'(BURST_LEN - 1);
         else if (left != '0)
            left <= left - 1'b1;
      end
   end

   assign wr_accept  = en & ~kill & (cmd.wr | (left != '0));
   assign wr_byte_en = {LANES{wr_accept}} & ~dqm;

   AST_READ_ENDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.rd |-> !wr_accept); // R8

   AST_FROZEN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !wr_accept); // R7

   AST_WRITE_TAKES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cmd.wr && !kill) |-> wr_accept); // R4

endmodule

// File: rtl/sdram_mrs_guard.sv
module sdram_mrs_guard
   import sdram_dq_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    en,
   input  dq_cmd_t cmd,
   output logic    mode_set_err
);

   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed        <= 1'b0;
         mode_set_err <= 1'b0;
      end else begin
         mode_set_err <= en & armed & cmd_any(cmd);
         if (en)
            armed <= cmd.mrs;
      end
   end

   AST_MRS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      ((en && cmd.mrs) ##1 (en && cmd_any(cmd))) |=> mode_set_err); // R9

   AST_MRS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_any(cmd) |=> !mode_set_err); // R9

endmodule

// File: rtl/sdram_dq_timing.sv
module sdram_dq_timing
   import sdram_dq_pkg::*;
#(
   parameter int DW        = 8,
   parameter int LANE_W    = 8,
   parameter int BURST_LEN = 4,
   parameter int MAX_CL    = 3,
   parameter int MASK_LAT  = 2,
   localparam int LANES    = DW / LANE_W,
   localparam int CL_W     = $clog2(MAX_CL + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cke,
   input  logic             cmd_read,
   input  logic             cmd_write,
   input  logic             cmd_precharge,
   input  logic             cmd_burst_stop,
   input  logic             cmd_mode_set,
   input  logic [CL_W-1:0]  cas_lat,
   input  logic [DW-1:0]    rd_beat,
   input  logic [LANES-1:0] dqm,
   output logic [LANES-1:0] dq_oe,
   output logic             dq_valid,
   output logic [DW-1:0]    dq_out,
   output logic             wr_accept,
   output logic [LANES-1:0] wr_byte_en,
   output logic             mode_set_err
);

   if (LANE_W < 1 || DW % LANE_W != 0) begin : g_bad_lane
      $error("DW must be a whole number of lanes");
   end
   if (BURST_LEN < 1) begin : g_bad_burst
      $error("BURST_LEN must be at least 1");
   end
   if (MAX_CL < 1) begin : g_bad_cl
      $error("MAX_CL must be at least 1");
   end
   if (MASK_LAT < 1) begin : g_bad_mask
      $error("MASK_LAT must be at least 1");
   end

   // Clock enable takes effect one edge after it is sampled
   logic en;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en <= 1'b1;
      else
         en <= cke;
   end

   dq_cmd_t cmd;
   assign cmd = '{rd: cmd_read, wr: cmd_write, pre: cmd_precharge,
                  bst: cmd_burst_stop, mrs: cmd_mode_set};

   sdram_rd_pipe #(
      .DW(DW), .LANE_W(LANE_W), .BURST_LEN(BURST_LEN),
      .MAX_CL(MAX_CL), .MASK_LAT(MASK_LAT)
   ) u_rd (
      .clk(clk), .rst_n(rst_n), .en(en), .cmd(cmd), .cas_lat(cas_lat),
      .rd_beat(rd_beat), .dqm(dqm),
      .dq_valid(dq_valid), .dq_oe(dq_oe), .dq_out(dq_out)
   );

   sdram_wr_gate #(
      .BURST_LEN(BURST_LEN), .LANES(LANES)
   ) u_wr (
      .clk(clk), .rst_n(rst_n), .en(en), .cmd(cmd), .dqm(dqm),
      .wr_accept(wr_accept), .wr_byte_en(wr_byte_en)
   );

   sdram_mrs_guard u_mrs (
      .clk(clk), .rst_n(rst_n), .en(en), .cmd(cmd),
      .mode_set_err(mode_set_err)
   );

   AST_OE_ONLY_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_valid |-> (dq_oe == '0 && dq_out == '0)); // R2

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (!dq_valid && !mode_set_err)); // R10

endmodule

// File: tb/tb_sdram_dq_timing.sv
module tb_sdram_dq_timing;

   localparam int CLK_P = 10;
   localparam int DW    = 16;
   localparam int LN    = 2;
   localparam int BL    = 4;
   localparam int MCL   = 3;

   logic          clk = 0;
   logic          rst_n = 0;
   logic          cke = 1;
   logic          cmd_read = 0, cmd_write = 0, cmd_precharge = 0;
   logic          cmd_burst_stop = 0, cmd_mode_set = 0;
   logic [1:0]    cas_lat = 2'd2;
   logic [DW-1:0] rd_beat = '0;
   logic [LN-1:0] dqm = '0;
   logic [LN-1:0] dq_oe;
   logic          dq_valid;
   logic [DW-1:0] dq_out;
   logic          wr_accept;
   logic [LN-1:0] wr_byte_en;
   logic          mode_set_err;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   always #(CLK_P/2) clk = ~clk;

   sdram_dq_timing #(.DW(DW), .LANE_W(8), .BURST_LEN(BL), .MAX_CL(MCL), .MASK_LAT(2)) dut (
      .clk(clk), .rst_n(rst_n), .cke(cke),
      .cmd_read(cmd_read), .cmd_write(cmd_write), .cmd_precharge(cmd_precharge),
      .cmd_burst_stop(cmd_burst_stop), .cmd_mode_set(cmd_mode_set),
      .cas_lat(cas_lat), .rd_beat(rd_beat), .dqm(dqm),
      .dq_oe(dq_oe), .dq_valid(dq_valid), .dq_out(dq_out),
      .wr_accept(wr_accept), .wr_byte_en(wr_byte_en), .mode_set_err(mode_set_err)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic quiet();
      cmd_read = 0; cmd_write = 0; cmd_precharge = 0;
      cmd_burst_stop = 0; cmd_mode_set = 0; dqm = '0; cke = 1;
   endtask

   function automatic logic [DW-1:0] pat(input int j);
      return 16'h1020 + 16'(j) * 16'h0101;
   endfunction

   task automatic drain();
      quiet();
      repeat (8) tick();
   endtask

   // R10
   task automatic t_reset();
      check("R10 valid", 32'(dq_valid), 0);
      check("R10 oe", 32'(dq_oe), 0);
      check("R10 data", 32'(dq_out), 0);
      check("R10 accept", 32'(wr_accept), 0);
      check("R10 byte_en", 32'(wr_byte_en), 0);
      check("R10 mode err", 32'(mode_set_err), 0);
   endtask

   // R1: plain read at a given latency
   task automatic t_read(input int cl);
      cas_lat = 2'(cl);
      for (int t = 1; t <= BL + MCL + 1; t++) begin
         rd_beat  = pat(t - 1);
         cmd_read = (t == 1);
         tick();
         cmd_read = 0;
         begin
            int j = t - cl;
            bit v = (j >= 0 && j < BL);
            check($sformatf("R1 cl%0d valid t%0d", cl, t), 32'(dq_valid), 32'(v));
            check($sformatf("R1 cl%0d data t%0d", cl, t), 32'(dq_out), v ? 32'(pat(j)) : 0);
         end
      end
      drain();
   endtask

   // R2: read mask on lane 0 sampled at edge 3, CL=2
   task automatic t_read_mask();
      cas_lat = 2'd2;
      for (int t = 1; t <= 7; t++) begin
         rd_beat  = pat(t - 1);
         cmd_read = (t == 1);
         dqm      = (t == 3) ? 2'b01 : 2'b00;
         tick();
         cmd_read = 0;
         begin
            int j = t - 2;
            bit v = (j >= 0 && j < BL);
            logic [1:0] eo = v ? ((t == 4) ? 2'b10 : 2'b11) : 2'b00;
            logic [15:0] ed = v ? pat(j) & {{8{eo[1]}}, {8{eo[0]}}} : 16'h0;
            check($sformatf("R2 oe t%0d", t), 32'(dq_oe), 32'(eo));
            check($sformatf("R2 data t%0d", t), 32'(dq_out), 32'(ed));
         end
      end
      drain();
   endtask

   // R5 (precharge) or R6 (burst stop) at edge 3, so two beats were issued
   task automatic t_cut(input bit use_pre, input int cl);
      cas_lat = 2'(cl);
      for (int t = 1; t <= 8; t++) begin
         rd_beat        = pat(t - 1);
         cmd_read       = (t == 1);
         cmd_precharge  = use_pre && (t == 3);
         cmd_burst_stop = !use_pre && (t == 3);
         tick();
         cmd_read = 0; cmd_precharge = 0; cmd_burst_stop = 0;
         begin
            int j = t - cl;
            bit v = (j >= 0 && j < 2);
            string r = use_pre ? "R5" : "R6";
            check($sformatf("%s valid t%0d", r, t), 32'(dq_valid), 32'(v));
            check($sformatf("%s data t%0d", r, t), 32'(dq_out), v ? 32'(pat(j)) : 0);
         end
      end
      drain();
   endtask

   // R7: cke low sampled at edge 3, edge 4 frozen, CL=2
   task automatic t_cke();
      bit          ev [7] = '{0, 1, 1, 1, 1, 1, 0};
      logic [15:0] ed [7];
      ed = '{16'h0, pat(0), pat(1), pat(1), pat(2), pat(4), 16'h0};
      cas_lat = 2'd2;
      for (int t = 1; t <= 7; t++) begin
         rd_beat  = pat(t - 1);
         cmd_read = (t == 1);
         cke      = (t != 3);
         tick();
         cmd_read = 0;
         if (t == 3) begin
            cmd_write = 1;
            #1;
            check("R7 no accept frozen", 32'(wr_accept), 0);
            cmd_write = 0;
         end
         check($sformatf("R7 valid t%0d", t), 32'(dq_valid), 32'(ev[t-1]));
         check($sformatf("R7 data t%0d", t), 32'(dq_out), 32'(ed[t-1]));
      end
      drain();
   endtask

   // R3, R4: write burst with zero-latency mask
   task automatic t_write();
      for (int k = 0; k <= BL; k++) begin
         cmd_write = (k == 0);
         dqm = (k == 0) ? 2'b01 : (k == 2) ? 2'b10 : 2'b00;
         #1;
         begin
            bit a = (k < BL);
            check($sformatf("R4 accept beat%0d", k), 32'(wr_accept), 32'(a));
            check($sformatf("R3 byte_en beat%0d", k), 32'(wr_byte_en), a ? 32'(~dqm & 2'b11) : 0);
         end
         tick();
      end
      drain();
   endtask

   // R8: read in the second beat of a write
   task automatic t_rd_over_wr();
      cmd_write = 1;
      #1;
      check("R8 write start", 32'(wr_accept), 1);
      tick();
      cmd_write = 0; cmd_read = 1;
      #1;
      check("R8 read cycle", 32'(wr_accept), 0);
      tick();
      cmd_read = 0;
      #1;
      check("R8 after read", 32'(wr_accept), 0);
      tick();
      check("R8 after read 2", 32'(wr_accept), 0);
      drain();
   endtask

   // R9: mode set spacing
   task automatic t_mode_set();
      cmd_mode_set = 1;
      tick();
      cmd_mode_set = 0; cmd_precharge = 1;
      tick();
      cmd_precharge = 0;
      check("R9 flagged", 32'(mode_set_err), 1);
      tick();
      check("R9 pulse ends", 32'(mode_set_err), 0);
      cmd_mode_set = 1;
      tick();
      cmd_mode_set = 0;
      tick();
      check("R9 gap ok 1", 32'(mode_set_err), 0);
      cmd_precharge = 1;
      tick();
      cmd_precharge = 0;
      check("R9 gap ok 2", 32'(mode_set_err), 0);
      drain();
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      quiet();
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1;
      tick();
      t_reset();
      t_read(1);
      t_read(2);
      t_read(3);
      t_read_mask();
      t_cut(1'b1, 3);
      t_cut(1'b1, 2);
      t_cut(1'b0, 2);
      t_cut(1'b0, 1);
      t_cke();
      t_write();
      t_rd_over_wr();
      t_mode_set();
      done = 1;
      summary();
      $finish;
   end

endmodule